// File: doc/BRIEF.md
# Register Fault Injection Controller

This block owns a bank of design flip-flops and corrupts chosen bits of it at one exact clock cycle, so that the functional effect of soft errors can be studied in emulation. In normal operation the bank simply captures its data input on every clock edge. Software-free configuration inputs set the cycle at which to strike, a mask of the bits to corrupt, the largest number of bits allowed to be hit at once, the fault model, the value used by the stuck-at model and whether the fault is transient or permanent.

After the block is armed, a cycle counter starts from zero. When the counter matches the programmed cycle, the masked bits are replaced by their corrupted values and a one-cycle done pulse is raised. A transient fault lasts one cycle. A permanent fault freezes the corrupted bits until the block is disarmed or reset. The sequencer has four states. IDLE accepts configuration. WAIT counts cycles toward the target. HOLD keeps a permanent fault in place. SPENT rests after a transient fault. The transitions are: IDLE to WAIT on arm; WAIT to IDLE on disarm (abort); WAIT to HOLD on the strike when the fault is permanent; WAIT to SPENT on the strike when it is transient; HOLD to IDLE and SPENT to IDLE on disarm.

Top module: `fault_inj_ctrl`

## Requirements
- R1: After reset, q_out is all zeros and armed, cfg_err and inj_done are 0.
- R2: Except on a strike edge or while a permanent fault is held, q_out equals the d_in value that was present at the previous rising clock edge.
- R3: If arm is sampled high at edge E while idle, the strike happens at edge E+T+1, where T is the programmed cycle. inj_done is high for exactly the one cycle that follows that edge, and q_out shows the fault in that same cycle.
- R4: Fault model 2'b00 (flip): on the strike, each masked bit becomes the inverse of its value in q_out just before the edge.
- R5: Fault model 2'b01 forces each masked bit to 1, and model 2'b10 forces each masked bit to 0.
- R6: Fault model 2'b11 (stuck-at) forces each masked bit to the value of cfg_stuck_val.
- R7: On the strike, bits outside the mask capture d_in as usual. With cfg_permanent = 0, all bits capture d_in again from the next edge on, and inj_done stays low.
- R8: With cfg_permanent = 1, the masked bits keep their corrupted value on every edge until the edge at which disarm is sampled high. On that edge the whole bank captures d_in, and armed falls.
- R9: A configuration write whose mask has more set bits than cfg_mult is rejected: cfg_err goes to 1 and the stored configuration is kept. An accepted write clears cfg_err.
- R10: Configuration writes are ignored while armed is 1. A later strike uses the configuration that was stored before arming.
- R11: disarm sampled high while waiting returns the block to idle with no strike. inj_done stays low and q_out keeps following d_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock of the register bank and the controller |
| rst_n | input | 1 | Active-low synchronous reset |
| d_in | input | W | Next-state data of the register bank |
| q_out | output | W | Current (possibly corrupted) register contents |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mask | input | W | Bits to corrupt |
| cfg_mult | input | MW | Largest allowed number of corrupted bits |
| cfg_cycle | input | CNT_W | Strike cycle, counted from arming |
| cfg_model | input | 2 | Fault model: 00 flip, 01 set, 10 clear, 11 stuck-at |
| cfg_stuck_val | input | 1 | Value forced by the stuck-at model |
| cfg_permanent | input | 1 | 1 holds the fault, 0 releases it after one cycle |
| arm | input | 1 | Start counting toward the strike |
| disarm | input | 1 | Abort or release; has priority over arm |
| armed | output | 1 | High whenever the sequencer is not idle |
| cfg_err | output | 1 | Last unlocked write was rejected |
| inj_done | output | 1 | One-cycle pulse with the corrupted value visible |

## Verification
The assertions assume that the mask, model and stuck value seen by the datapath only change through an accepted write, which happens only while idle. So across a held fault or a strike, the previous-cycle mask is the one in force. They also assume that rst_n is held low for at least one edge before any check matters. The stimulus respects this. It writes configuration only before arm, apart from one deliberate write while armed to show that it is ignored. It issues disarm and arm as single-cycle strobes. It keeps random multiplicity values at or above the mask population, except in the directed rejection case.

// File: rtl/fi_pkg.sv
package fi_pkg;
    typedef enum logic [1:0] {
        MDL_FLIP  = 2'b00,
        MDL_SET   = 2'b01,
        MDL_CLR   = 2'b10,
        MDL_STUCK = 2'b11
    } fault_mdl_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_SPENT
    } fi_state_t;
endpackage

// File: rtl/fi_cfg_regs.sv
module fi_cfg_regs
    import fi_pkg::*;
#(
    parameter int W     = 16,
    parameter int MW    = $clog2(W + 1),
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             locked,
    input  logic             wr,
    input  logic [W-1:0]     mask_in,
    input  logic [MW-1:0]    mult_in,
    input  logic [CNT_W-1:0] cycle_in,
    input  logic [1:0]       model_in,
    input  logic             sval_in,
    input  logic             perm_in,
    output logic [W-1:0]     mask_q,
    output logic [CNT_W-1:0] cycle_q,
    output fault_mdl_t       model_q,
    output logic             sval_q,
    output logic             perm_q,
    output logic             err_q
);
    logic [MW-1:0] pop;
    logic          accept;
    logic          reject;

    always_comb begin
        pop = '0;
        for (int i = 0; i < W; i++) begin
            pop = pop + MW'(mask_in[i]);
        end
    end

    assign accept = wr && !locked && (pop <= mult_in);
    assign reject = wr && !locked && (pop > mult_in);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            cycle_q <= '0;
            model_q <= MDL_FLIP;
            sval_q  <= 1'b0;
            perm_q  <= 1'b0;
            err_q   <= 1'b0;
        end else if (accept) begin
            mask_q  <= mask_in;
            cycle_q <= cycle_in;
            model_q <= fault_mdl_t'(model_in);
            sval_q  <= sval_in;
            perm_q  <= perm_in;
            err_q   <= 1'b0;
        end else if (reject) begin
            err_q   <= 1'b1;
        end
    end

    AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> ($stable(mask_q) && $stable(cycle_q) && $stable(model_q))); // R10

    AST_OVER_MULT_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !locked && ($countones(mask_in) > int'(mult_in)))
            |=> (err_q && $stable(mask_q))); // R9
endmodule

// File: rtl/fi_seq.sv
module fi_seq
    import fi_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic [CNT_W-1:0] target,
    input  logic             perm,
    output logic             fire,
    output logic             hold,
    output logic             busy,
    output logic             inj_done
);
    fi_state_t        st, st_nxt;
    logic [CNT_W-1:0] cnt;

    // state register and cycle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st <= st_nxt;
            if (st == ST_IDLE) begin
                cnt <= '0;
            end else if (st == ST_WAIT && !fire) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:  if (arm && !disarm) st_nxt = ST_WAIT;
            ST_WAIT: begin
                if (disarm)    st_nxt = ST_IDLE;
                else if (fire) st_nxt = perm ? ST_HOLD : ST_SPENT;
            end
            ST_HOLD:  if (disarm) st_nxt = ST_IDLE;
            ST_SPENT: if (disarm) st_nxt = ST_IDLE;
            default:  st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    assign fire = (st == ST_WAIT) && !disarm && (cnt == target);
    assign hold = (st == ST_HOLD) && !disarm;
    assign busy = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (!rst_n) inj_done <= 1'b0;
        else        inj_done <= fire;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        inj_done |=> !inj_done); // R3

    AST_SINGLE_STRIKE: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> (busy && !fire)); // R3

    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && busy) |=> (!busy && !inj_done)); // R11
endmodule

// File: rtl/fi_corrupt.sv
module fi_corrupt
    import fi_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    input  logic [W-1:0] mask,
    input  fault_mdl_t   model,
    input  logic         sval,
    input  logic         fire,
    input  logic         hold,
    output logic [W-1:0] q
);
    logic [W-1:0] bad;
    logic [W-1:0] nxt;

    always_comb begin
        unique case (model)
            MDL_FLIP:  bad = ~q;
            MDL_SET:   bad = '1;
            MDL_CLR:   bad = '0;
            MDL_STUCK: bad = {W{sval}};
            default:   bad = ~q;
        endcase
        if (fire)      nxt = (d_in & ~mask) | (bad & mask);
        else if (hold) nxt = (d_in & ~mask) | (q & mask);
        else           nxt = d_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end

    AST_PLAIN_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !hold) |=> (q == $past(d_in))); // R2

    AST_FLIP_INVERTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && model == MDL_FLIP) |=> ((q & mask) == (~$past(q) & mask))); // R4

    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ((q & mask) == ($past(q) & mask))); // R8
endmodule

// File: rtl/fault_inj_ctrl.sv
module fault_inj_ctrl
    import fi_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 32,
    localparam int MW   = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [W-1:0]     d_in,
    output logic [W-1:0]     q_out,
    input  logic             cfg_wr,
    input  logic [W-1:0]     cfg_mask,
    input  logic [MW-1:0]    cfg_mult,
    input  logic [CNT_W-1:0] cfg_cycle,
    input  logic [1:0]       cfg_model,
    input  logic             cfg_stuck_val,
    input  logic             cfg_permanent,
    input  logic             arm,
    input  logic             disarm,
    output logic             armed,
    output logic             cfg_err,
    output logic             inj_done
);
    logic [W-1:0]     mask_q;
    logic [CNT_W-1:0] cycle_q;
    fault_mdl_t       model_q;
    logic             sval_q;
    logic             perm_q;
    logic             fire;
    logic             hold;
    logic             busy;

    fi_cfg_regs #(.W(W), .MW(MW), .CNT_W(CNT_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .locked   (busy),
        .wr       (cfg_wr),
        .mask_in  (cfg_mask),
        .mult_in  (cfg_mult),
        .cycle_in (cfg_cycle),
        .model_in (cfg_model),
        .sval_in  (cfg_stuck_val),
        .perm_in  (cfg_permanent),
        .mask_q   (mask_q),
        .cycle_q  (cycle_q),
        .model_q  (model_q),
        .sval_q   (sval_q),
        .perm_q   (perm_q),
        .err_q    (cfg_err)
    );

    fi_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm      (arm),
        .disarm   (disarm),
        .target   (cycle_q),
        .perm     (perm_q),
        .fire     (fire),
        .hold     (hold),
        .busy     (busy),
        .inj_done (inj_done)
    );

    fi_corrupt #(.W(W)) u_dp (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (d_in),
        .mask  (mask_q),
        .model (model_q),
        .sval  (sval_q),
        .fire  (fire),
        .hold  (hold),
        .q     (q_out)
    );

    assign armed = busy;

    AST_STRIKE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        inj_done |-> armed); // R3
endmodule

// File: tb/test_fault_inj_ctrl.sv
module test_fault_inj_ctrl;
    localparam int W  = 16;
    localparam int MW = $clog2(W + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  d_in = '0;
    logic [W-1:0]  q_out;
    logic          cfg_wr = 1'b0;
    logic [W-1:0]  cfg_mask = '0;
    logic [MW-1:0] cfg_mult = '0;
    logic [31:0]   cfg_cycle = '0;
    logic [1:0]    cfg_model = '0;
    logic          cfg_stuck_val = 1'b0;
    logic          cfg_permanent = 1'b0;
    logic          arm = 1'b0;
    logic          disarm = 1'b0;
    logic          armed, cfg_err, inj_done;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fault_inj_ctrl #(.W(W), .CNT_W(32)) i_fault_inj_ctrl (
        .clk(clk), .rst_n(rst_n), .d_in(d_in), .q_out(q_out),
        .cfg_wr(cfg_wr), .cfg_mask(cfg_mask), .cfg_mult(cfg_mult),
        .cfg_cycle(cfg_cycle), .cfg_model(cfg_model),
        .cfg_stuck_val(cfg_stuck_val), .cfg_permanent(cfg_permanent),
        .arm(arm), .disarm(disarm), .armed(armed), .cfg_err(cfg_err),
        .inj_done(inj_done)
    );

    function automatic int popc(logic [W-1:0] m);
        int n = 0;
        for (int i = 0; i < W; i++) n += int'(m[i]);
        return n;
    endfunction

    function automatic logic [W-1:0] corrupt(logic [1:0] mdl, logic sv, logic [W-1:0] prev);
        case (mdl)
            2'b00:   return ~prev;
            2'b01:   return '1;
            2'b10:   return '0;
            default: return {W{sv}};
        endcase
    endfunction

    function automatic logic [W-1:0] merge(logic [W-1:0] d, logic [W-1:0] f, logic [W-1:0] m);
        return (d & ~m) | (f & m);
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // sample and drive 1 ns after the rising edge
    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic write_cfg(logic [W-1:0] m, int mult, int cyc, logic [1:0] mdl, logic sv, logic pm);
        cfg_wr = 1'b1; cfg_mask = m; cfg_mult = MW'(mult); cfg_cycle = cyc;
        cfg_model = mdl; cfg_stuck_val = sv; cfg_permanent = pm;
        step();
        cfg_wr = 1'b0;
    endtask

    // arm, run to strike, check, then release; m/mdl/sv/pm/tgt are the expected stored config
    task automatic run_strike(logic [W-1:0] m, logic [1:0] mdl, logic sv, logic pm, int tgt);
        logic [W-1:0] prevq, fq;
        arm = 1'b1;
        step();
        arm = 1'b0;
        chk(armed == 1'b1, "R3 armed", 32'(armed), 32'd1);
        for (int k = 0; k <= tgt; k++) begin
            d_in = W'($urandom);
            prevq = q_out;
            step();
            if (k < tgt) begin
                chk(q_out == d_in && !inj_done, "R2 pre-strike capture", 32'(q_out), 32'(d_in));
            end else begin
                fq = merge(d_in, corrupt(mdl, sv, prevq), m);
                chk(q_out == fq, mdl == 2'b00 ? "R4 flip" : (mdl == 2'b11 ? "R6 stuck" : "R5 set/clear"),
                    32'(q_out), 32'(fq));
                chk(inj_done == 1'b1, "R3 done pulse", 32'(inj_done), 32'd1);
            end
        end
        fq = q_out;
        for (int k = 0; k < 3; k++) begin
            d_in = W'($urandom);
            step();
            if (pm) chk(q_out == merge(d_in, fq, m), "R8 hold", 32'(q_out), 32'(merge(d_in, fq, m)));
            else    chk(q_out == d_in, "R7 release", 32'(q_out), 32'(d_in));
            chk(inj_done == 1'b0, "R3 single pulse", 32'(inj_done), 32'd0);
        end
        disarm = 1'b1;
        d_in = W'($urandom);
        step();
        disarm = 1'b0;
        chk(q_out == d_in && !armed, "R8 disarm release", 32'({armed, q_out}), 32'(d_in));
    endtask

    initial begin
        #200000;
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] m;
        int mult, tgt;
        logic [1:0] mdl;
        logic sv, pm;
        void'($urandom(32'd4242));
        step(); step();
        chk(q_out == '0 && !armed && !cfg_err && !inj_done, "R1 reset",
            32'({armed, cfg_err, inj_done, q_out}), 32'd0);
        rst_n = 1'b1;
        d_in = 16'hA5C3;
        step();
        chk(q_out == 16'hA5C3, "R2 capture", 32'(q_out), 32'hA5C3);

        // directed: each model, target 0 and larger
        write_cfg(16'h00F1, 5, 0, 2'b00, 1'b0, 1'b0);
        chk(!cfg_err, "R9 accept", 32'(cfg_err), 32'd0);
        run_strike(16'h00F1, 2'b00, 1'b0, 1'b0, 0);
        write_cfg(16'h0F00, 4, 5, 2'b01, 1'b0, 1'b1);
        run_strike(16'h0F00, 2'b01, 1'b0, 1'b1, 5);
        write_cfg(16'hF00F, 8, 3, 2'b10, 1'b0, 1'b0);
        run_strike(16'hF00F, 2'b10, 1'b0, 1'b0, 3);
        write_cfg(16'h8001, 2, 2, 2'b11, 1'b1, 1'b1);
        run_strike(16'h8001, 2'b11, 1'b1, 1'b1, 2);

        // directed: over-multiplicity rejection keeps old config
        write_cfg(16'h001F, 3, 1, 2'b01, 1'b0, 1'b0);
        chk(cfg_err == 1'b1, "R9 reject flag", 32'(cfg_err), 32'd1);
        run_strike(16'h8001, 2'b11, 1'b1, 1'b1, 2);
        write_cfg(16'h0003, 2, 4, 2'b00, 1'b0, 1'b0);
        chk(cfg_err == 1'b0, "R9 clear flag", 32'(cfg_err), 32'd0);

        // directed: write while armed is ignored
        arm = 1'b1; step(); arm = 1'b0;
        write_cfg(16'hFF00, 16, 0, 2'b01, 1'b0, 1'b1);
        chk(cfg_err == 1'b0, "R10 locked write", 32'(cfg_err), 32'd0);
        disarm = 1'b1; step(); disarm = 1'b0;
        run_strike(16'h0003, 2'b00, 1'b0, 1'b0, 4);

        // directed: abort before target
        write_cfg(16'h00FF, 8, 6, 2'b01, 1'b0, 1'b0);
        arm = 1'b1; step(); arm = 1'b0;
        step(); step();
        disarm = 1'b1; step(); disarm = 1'b0;
        chk(!armed, "R11 idle after abort", 32'(armed), 32'd0);
        for (int k = 0; k < 10; k++) begin
            d_in = W'($urandom);
            step();
            chk(q_out == d_in && !inj_done, "R11 no strike", 32'({inj_done, q_out}), 32'(d_in));
        end

        // constrained random
        for (int n = 0; n < 24; n++) begin
            m = W'($urandom);
            mult = popc(m) + int'($urandom % 2);
            if (mult > W) mult = W;
            tgt = int'($urandom % 16);
            mdl = 2'($urandom);
            sv = 1'($urandom);
            pm = 1'($urandom);
            write_cfg(m, mult, tgt, mdl, sv, pm);
            chk(!cfg_err, "R9 random accept", 32'(cfg_err), 32'd0);
            run_strike(m, mdl, sv, pm, tgt);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule